// File: doc/BRIEF.md
# Serializing Bus Bridge with XOR Scrambling

This block sits between a processor's memory-mapped slave port and a narrow point-to-point link toward a remote bridge. Each 32-bit upstream write is sent over one outbound 8-bit lane. Each upstream read is rebuilt from bytes that arrive on a separate inbound 8-bit lane. The 24-bit address passes through unchanged, held stable for the whole transfer. The upstream master sees an ordinary slave that only adds wait cycles.

Data may be scrambled in both directions. Scrambling XORs the data with a 32-bit mask built by interleaving nibbles of two stored 48-bit keys, a pass key and a card key. Each word is handled on its own, so the same mask scrambles and unscrambles.

A second, small slave port lets software load and read back both keys and the scramble enable. The keys and the enable are cleared by reset.

Top module: `ser_xor_bridge`

## Requirements
- R1: A write is sent as four outbound beats, least significant byte first. Each beat is presented with `lk_tx_valid` high. `lk_tx_data` is held stable until the cycle in which `lk_tx_ack` is high, and no more than four beats are sent per transfer.
- R2: During a transfer, `lk_addr` equals the upstream address that the master is holding, without modification.
- R3: `up_waitreq` stays high from acceptance until all beats are done. It then drops for exactly one cycle, and in that cycle the transfer completes.
- R4: A read collects four inbound bytes, least significant first. One byte is taken in each cycle in which `lk_rx_valid` is high. The rebuilt word is on `up_rdata` in the cycle `up_waitreq` is low.
- R5: The mask is built from these nibbles, most significant first: pass[47:44], card[47:44], pass[43:40], card[43:40], pass[7:4], card[7:4], pass[3:0], card[3:0].
- R6: With the enable set, write data is XORed with the mask before it is sent, and read data is XORed with the mask after it is rebuilt. With the enable clear, data passes unmodified.
- R7: The mask is captured when a transfer is accepted. A configuration write in that same cycle, or during the transfer, affects only later transfers.
- R8: The configuration map uses these word offsets on `cfg_addr`:
  - 0: pass key bits 31:0
  - 1: pass key bits 47:32, in data bits 15:0
  - 2: card key bits 31:0
  - 3: card key bits 47:32, in data bits 15:0
  - 4: enable, in bit 0

  A read returns the stored value on `cfg_rdata` one cycle after `cfg_read`.
- R9: Reset clears both keys and the enable, and leaves the bridge idle with `up_waitreq` high. Configuration reads of offsets 5 to 7 return zero.
- R10: Outside a transfer, `lk_active` and `lk_tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_addr | input | 24 | Upstream address |
| up_read | input | 1 | Upstream read request |
| up_write | input | 1 | Upstream write request |
| up_wdata | input | 32 | Upstream write data |
| up_rdata | output | 32 | Upstream read data |
| up_waitreq | output | 1 | Wait request; low for the one completing cycle |
| cfg_addr | input | 3 | Configuration word offset |
| cfg_read | input | 1 | Configuration read strobe |
| cfg_write | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, registered |
| lk_addr | output | 24 | Address carried to the remote side |
| lk_is_write | output | 1 | High when the current transfer is a write |
| lk_active | output | 1 | Transfer in progress on the link |
| lk_tx_data | output | 8 | Outbound byte |
| lk_tx_valid | output | 1 | Outbound byte valid |
| lk_tx_ack | input | 1 | Remote accepts the outbound byte |
| lk_rx_data | input | 8 | Inbound byte |
| lk_rx_valid | input | 1 | Inbound byte valid |

## Verification
A configuration write that turns scrambling on can land in the very cycle the link engine accepts an upstream write. The bench provokes this by raising `up_write` and `cfg_write` on the same clock edge. It judges the result from the bytes seen on the outbound lane: they must be the unscrambled word. The transfer that follows must carry the masked word. A second case changes the enable while a transfer is already in flight, with the same expectation. The remote model stalls the acknowledge and inbound valid on alternate cycles, so beat holding and collection are exercised with gaps.

// File: rtl/sxb_pkg.sv
package sxb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_RECV,
    ST_DONE
  } link_st_t;

  localparam logic [2:0] OFF_PASS_LO = 3'd0;
  localparam logic [2:0] OFF_PASS_HI = 3'd1;
  localparam logic [2:0] OFF_CARD_LO = 3'd2;
  localparam logic [2:0] OFF_CARD_HI = 3'd3;
  localparam logic [2:0] OFF_ENABLE  = 3'd4;

  // Interleave nibbles of the two 48-bit keys into the 32-bit mask.
  function automatic logic [31:0] build_mask(input logic [47:0] pk,
                                             input logic [47:0] ck);
    return {pk[47:44], ck[47:44], pk[43:40], ck[43:40],
            pk[7:4],   ck[7:4],   pk[3:0],   ck[3:0]};
  endfunction

endpackage

// File: rtl/sxb_key_regs.sv
module sxb_key_regs
  import sxb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int KEY_W  = 48,
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_read,
  input  logic              cfg_write,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [DATA_W-1:0] mask_o
);
  localparam int HI_W = KEY_W - DATA_W;

  logic [KEY_W-1:0] pass_q;
  logic [KEY_W-1:0] card_q;
  logic             en_q;

  // Write side of the configuration port.
  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q <= '0;
      card_q <= '0;
      en_q   <= 1'b0;
    end else if (cfg_write) begin
      case (3'(cfg_addr))
        OFF_PASS_LO: pass_q[DATA_W-1:0]     <= cfg_wdata;
        OFF_PASS_HI: pass_q[KEY_W-1:DATA_W] <= cfg_wdata[HI_W-1:0];
        OFF_CARD_LO: card_q[DATA_W-1:0]     <= cfg_wdata;
        OFF_CARD_HI: card_q[KEY_W-1:DATA_W] <= cfg_wdata[HI_W-1:0];
        OFF_ENABLE:  en_q                   <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  // Read side: registered, one cycle after the strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_read) begin
      case (3'(cfg_addr))
        OFF_PASS_LO: cfg_rdata <= pass_q[DATA_W-1:0];
        OFF_PASS_HI: cfg_rdata <= {{(DATA_W-HI_W){1'b0}}, pass_q[KEY_W-1:DATA_W]};
        OFF_CARD_LO: cfg_rdata <= card_q[DATA_W-1:0];
        OFF_CARD_HI: cfg_rdata <= {{(DATA_W-HI_W){1'b0}}, card_q[KEY_W-1:DATA_W]};
        OFF_ENABLE:  cfg_rdata <= {{(DATA_W-1){1'b0}}, en_q};
        default:     cfg_rdata <= '0;
      endcase
    end
  end

  assign mask_o = en_q ? build_mask(pass_q, card_q) : '0;

endmodule

// File: rtl/sxb_link_engine.sv
module sxb_link_engine
  import sxb_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_read,
  input  logic              up_write,
  input  logic [DATA_W-1:0] up_wdata,
  output logic [DATA_W-1:0] up_rdata,
  output logic              up_waitreq,
  input  logic [DATA_W-1:0] mask_i,
  output logic [ADDR_W-1:0] lk_addr,
  output logic              lk_is_write,
  output logic              lk_active,
  output logic [BEAT_W-1:0] lk_tx_data,
  output logic              lk_tx_valid,
  input  logic              lk_tx_ack,
  input  logic [BEAT_W-1:0] lk_rx_data,
  input  logic              lk_rx_valid
);
  localparam int BEATS = DATA_W / BEAT_W;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  link_st_t          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rx_word;

  // Shift register with the incoming byte entering at the top.
  assign rx_word = {lk_rx_data, sh_q[DATA_W-1:BEAT_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      mask_q  <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (up_write) begin
            sh_q   <= up_wdata ^ mask_i;
            mask_q <= mask_i;
            addr_q <= up_addr;
            wr_q   <= 1'b1;
            st_q   <= ST_SEND;
          end else if (up_read) begin
            mask_q <= mask_i;
            addr_q <= up_addr;
            wr_q   <= 1'b0;
            st_q   <= ST_RECV;
          end
        end
        ST_SEND: begin
          if (lk_tx_ack) begin
            sh_q  <= sh_q >> BEAT_W;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) st_q <= ST_DONE;
          end
        end
        ST_RECV: begin
          if (lk_rx_valid) begin
            sh_q  <= rx_word;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              rdata_q <= rx_word ^ mask_q;
              st_q    <= ST_DONE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign up_waitreq  = (st_q != ST_DONE);
  assign up_rdata    = rdata_q;
  assign lk_active   = (st_q == ST_SEND) || (st_q == ST_RECV);
  assign lk_tx_valid = (st_q == ST_SEND);
  assign lk_tx_data  = sh_q[BEAT_W-1:0];
  assign lk_addr     = addr_q;
  assign lk_is_write = wr_q;

endmodule

// File: rtl/ser_xor_bridge.sv
module ser_xor_bridge #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 8,
  parameter int KEY_W  = 48,
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_read,
  input  logic              up_write,
  input  logic [DATA_W-1:0] up_wdata,
  output logic [DATA_W-1:0] up_rdata,
  output logic              up_waitreq,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_read,
  input  logic              cfg_write,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [ADDR_W-1:0] lk_addr,
  output logic              lk_is_write,
  output logic              lk_active,
  output logic [BEAT_W-1:0] lk_tx_data,
  output logic              lk_tx_valid,
  input  logic              lk_tx_ack,
  input  logic [BEAT_W-1:0] lk_rx_data,
  input  logic              lk_rx_valid
);
  logic [DATA_W-1:0] mask_w;

  sxb_key_regs #(
    .DATA_W(DATA_W),
    .KEY_W (KEY_W),
    .CFG_AW(CFG_AW)
  ) keys_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_addr (cfg_addr),
    .cfg_read (cfg_read),
    .cfg_write(cfg_write),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .mask_o   (mask_w)
  );

  sxb_link_engine #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .BEAT_W(BEAT_W)
  ) eng_i (
    .clk        (clk),
    .rst        (rst),
    .up_addr    (up_addr),
    .up_read    (up_read),
    .up_write   (up_write),
    .up_wdata   (up_wdata),
    .up_rdata   (up_rdata),
    .up_waitreq (up_waitreq),
    .mask_i     (mask_w),
    .lk_addr    (lk_addr),
    .lk_is_write(lk_is_write),
    .lk_active  (lk_active),
    .lk_tx_data (lk_tx_data),
    .lk_tx_valid(lk_tx_valid),
    .lk_tx_ack  (lk_tx_ack),
    .lk_rx_data (lk_rx_data),
    .lk_rx_valid(lk_rx_valid)
  );

endmodule

// File: rtl/sxb_checker.sv
module sxb_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_read,
  input logic              up_write,
  input logic              up_waitreq,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_active,
  input logic [BEAT_W-1:0] lk_tx_data,
  input logic              lk_tx_valid,
  input logic              lk_tx_ack
);
  localparam int BEATS = DATA_W / BEAT_W;

  logic [7:0] sent_q;

  always_ff @(posedge clk) begin
    if (rst || !lk_active) sent_q <= '0;
    else if (lk_tx_valid && lk_tx_ack) sent_q <= sent_q + 1'b1;
  end

  // R1: an unacknowledged beat stays put
  p_tx_hold_r1: assert property (@(posedge clk) disable iff (rst)
    lk_tx_valid && !lk_tx_ack |=> lk_tx_valid && $stable(lk_tx_data));

  // R1: never more than the word's beats per transfer
  p_beats_r1: assert property (@(posedge clk) disable iff (rst)
    lk_tx_valid |-> sent_q < 8'(BEATS));

  // R2: address carried through unchanged while the master holds it
  p_addr_r2: assert property (@(posedge clk) disable iff (rst)
    lk_active && (up_read || up_write) |-> lk_addr == up_addr);

  // R3: completion lasts one cycle and never overlaps link activity
  p_wait_r3: assert property (@(posedge clk) disable iff (rst)
    !up_waitreq |=> up_waitreq);

  p_done_r3: assert property (@(posedge clk) disable iff (rst)
    !up_waitreq |-> !lk_active);

  // R10: no outbound beat outside a transfer
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !lk_active |-> !lk_tx_valid);

  // R9: state right after reset
  p_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cfg_rdata == '0 && up_waitreq && !lk_active);

endmodule

bind ser_xor_bridge sxb_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .BEAT_W(BEAT_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .up_addr    (up_addr),
  .up_read    (up_read),
  .up_write   (up_write),
  .up_waitreq (up_waitreq),
  .cfg_rdata  (cfg_rdata),
  .lk_addr    (lk_addr),
  .lk_active  (lk_active),
  .lk_tx_data (lk_tx_data),
  .lk_tx_valid(lk_tx_valid),
  .lk_tx_ack  (lk_tx_ack)
);

// File: tb/ser_xor_bridge_tb_top.sv
`timescale 1ns/1ps
module ser_xor_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] up_addr = '0;
  logic        up_read = 1'b0;
  logic        up_write = 1'b0;
  logic [31:0] up_wdata = '0;
  logic [31:0] up_rdata;
  logic        up_waitreq;
  logic [2:0]  cfg_addr = '0;
  logic        cfg_read = 1'b0;
  logic        cfg_write = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [23:0] lk_addr;
  logic        lk_is_write;
  logic        lk_active;
  logic [7:0]  lk_tx_data;
  logic        lk_tx_valid;
  logic        lk_tx_ack = 1'b0;
  logic [7:0]  lk_rx_data = '0;
  logic        lk_rx_valid = 1'b0;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] cap_word = '0;
  logic [31:0] rd_src = '0;
  logic [23:0] seen_addr = '0;

  localparam logic [47:0] PASS_K = 48'hA1B2_C3D4_E5F6;
  localparam logic [47:0] CARD_K = 48'h1357_9BDF_2468;

  always #4 clk = ~clk;

  ser_xor_bridge dut_i (
    .clk(clk), .rst(rst),
    .up_addr(up_addr), .up_read(up_read), .up_write(up_write),
    .up_wdata(up_wdata), .up_rdata(up_rdata), .up_waitreq(up_waitreq),
    .cfg_addr(cfg_addr), .cfg_read(cfg_read), .cfg_write(cfg_write),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_addr(lk_addr), .lk_is_write(lk_is_write), .lk_active(lk_active),
    .lk_tx_data(lk_tx_data), .lk_tx_valid(lk_tx_valid), .lk_tx_ack(lk_tx_ack),
    .lk_rx_data(lk_rx_data), .lk_rx_valid(lk_rx_valid)
  );

  function automatic logic [31:0] exp_mask(input logic [47:0] p, input logic [47:0] c);
    logic [31:0] m;
    m[31:28] = p[47:44]; m[27:24] = c[47:44];
    m[23:20] = p[43:40]; m[19:16] = c[43:40];
    m[15:12] = p[7:4];   m[11:8]  = c[7:4];
    m[7:4]   = p[3:0];   m[3:0]   = c[3:0];
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Remote link model: acknowledges and supplies bytes on alternate cycles.
  initial begin
    int  tx_n;
    int  rx_n;
    bit  go;
    tx_n = 0; rx_n = 0; go = 1'b0;
    forever begin
      @(negedge clk);
      go = ~go;
      lk_tx_ack   = 1'b0;
      lk_rx_valid = 1'b0;
      if (!lk_active) begin
        tx_n = 0; rx_n = 0;
      end else begin
        seen_addr = lk_addr;
        if (lk_is_write) begin
          if (lk_tx_valid && go && tx_n < 4) begin
            cap_word[8*tx_n +: 8] = lk_tx_data;
            tx_n++;
            lk_tx_ack = 1'b1;
          end
        end else if (go && rx_n < 4) begin
          lk_rx_data  = rd_src[8*rx_n +: 8];
          lk_rx_valid = 1'b1;
          rx_n++;
        end
      end
    end
  end

  task automatic cfg_wr(input logic [2:0] off, input logic [31:0] val);
    @(negedge clk);
    cfg_addr = off; cfg_wdata = val; cfg_write = 1'b1;
    @(negedge clk);
    cfg_write = 1'b0;
  endtask

  task automatic cfg_rd(input logic [2:0] off, output logic [31:0] val);
    @(negedge clk);
    cfg_addr = off; cfg_read = 1'b1;
    @(negedge clk);
    cfg_read = 1'b0;
    val = cfg_rdata;
  endtask

  // Wait for completion, then release the request just after the edge.
  task automatic finish_xfer(input string req);
    while (up_waitreq) @(negedge clk);
    @(posedge clk);
    #1;
    up_write = 1'b0;
    up_read  = 1'b0;
    @(negedge clk);
    check(req, {31'd0, up_waitreq}, 32'd1);
  endtask

  task automatic do_write(input logic [23:0] a, input logic [31:0] d,
                          input logic [31:0] exp_wire, input string req);
    cap_word = '0;
    @(negedge clk);
    up_addr = a; up_wdata = d; up_write = 1'b1;
    @(negedge clk);
    finish_xfer("R3 single-cycle completion after write");
    check(req, cap_word, exp_wire);
    check("R2 address on link", {8'd0, seen_addr}, {8'd0, a});
  endtask

  task automatic do_read(input logic [23:0] a, input logic [31:0] wire_word,
                         input logic [31:0] exp, input string req);
    logic [31:0] got;
    rd_src = wire_word;
    @(negedge clk);
    up_addr = a; up_read = 1'b1;
    @(negedge clk);
    while (up_waitreq) @(negedge clk);
    got = up_rdata;
    @(posedge clk);
    #1;
    up_read = 1'b0;
    @(negedge clk);
    check("R3 single-cycle completion after read", {31'd0, up_waitreq}, 32'd1);
    check(req, got, exp);
    check("R2 address on link", {8'd0, seen_addr}, {8'd0, a});
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    check("R9 waitreq high after reset", {31'd0, up_waitreq}, 32'd1);
    check("R10 link idle after reset", {30'd0, lk_active, lk_tx_valid}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      cfg_rd(3'(i), v);
      check("R9 register cleared by reset", v, 32'd0);
    end
  endtask

  task automatic t_cfg_map();
    logic [31:0] v;
    cfg_wr(3'd0, PASS_K[31:0]);
    cfg_wr(3'd1, {16'hFFFF, PASS_K[47:32]});
    cfg_wr(3'd2, CARD_K[31:0]);
    cfg_wr(3'd3, {16'hFFFF, CARD_K[47:32]});
    cfg_rd(3'd0, v); check("R8 pass low", v, PASS_K[31:0]);
    cfg_rd(3'd1, v); check("R8 pass high", v, {16'd0, PASS_K[47:32]});
    cfg_rd(3'd2, v); check("R8 card low", v, CARD_K[31:0]);
    cfg_rd(3'd3, v); check("R8 card high", v, {16'd0, CARD_K[47:32]});
    cfg_rd(3'd4, v); check("R8 enable clear", v, 32'd0);
    cfg_wr(3'd6, 32'hDEAD_BEEF);
    cfg_rd(3'd6, v); check("R9 unmapped offset reads zero", v, 32'd0);
  endtask

  task automatic t_plain();
    do_write(24'h12_3456, 32'h4433_2211, 32'h4433_2211, "R1 plain write bytes LSB first (R6 off)");
    do_write(24'hFF_FF00, 32'h0000_0000, 32'h0000_0000, "R1 zero word");
    do_read(24'h00_0ABC, 32'h8877_6655, 32'h8877_6655, "R4 plain read assembly (R6 off)");
  endtask

  task automatic t_scrambled();
    logic [31:0] m;
    logic [31:0] v;
    m = exp_mask(PASS_K, CARD_K);
    cfg_wr(3'd4, 32'h0000_0003);
    cfg_rd(3'd4, v); check("R8 enable bit 0 only", v, 32'd1);
    do_write(24'h00_1000, 32'hCAFE_F00D, 32'hCAFE_F00D ^ m, "R5 R6 scrambled write");
    do_read(24'h00_2000, 32'h5A5A_A5A5 ^ m, 32'h5A5A_A5A5, "R5 R6 unscrambled read");
    cfg_wr(3'd4, 32'h0);
    do_write(24'h00_3000, 32'h0102_0304, 32'h0102_0304, "R6 disabled again");
  endtask

  task automatic t_collision();
    logic [31:0] m;
    m = exp_mask(PASS_K, CARD_K);
    cap_word = '0;
    @(negedge clk);
    up_addr = 24'h00_0044; up_wdata = 32'h7654_3210; up_write = 1'b1;
    cfg_addr = 3'd4; cfg_wdata = 32'd1; cfg_write = 1'b1;
    @(negedge clk);
    cfg_write = 1'b0;
    finish_xfer("R3 completion in collision");
    check("R7 enable in acceptance cycle not applied", cap_word, 32'h7654_3210);
    do_write(24'h00_0048, 32'h7654_3210, 32'h7654_3210 ^ m, "R7 next transfer scrambled");
    // Disable in mid-flight: current transfer keeps its captured mask.
    cap_word = '0;
    @(negedge clk);
    up_addr = 24'h00_004C; up_wdata = 32'h1111_2222; up_write = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cfg_addr = 3'd4; cfg_wdata = 32'd0; cfg_write = 1'b1;
    @(negedge clk);
    cfg_write = 1'b0;
    finish_xfer("R3 completion with mid-flight change");
    check("R7 mid-flight change ignored", cap_word, 32'h1111_2222 ^ m);
  endtask

  task automatic t_reset_clears();
    logic [31:0] v;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    cfg_rd(3'd0, v); check("R9 pass key cleared", v, 32'd0);
    cfg_rd(3'd2, v); check("R9 card key cleared", v, 32'd0);
    do_write(24'h00_0010, 32'h9ABC_DEF0, 32'h9ABC_DEF0, "R9 enable cleared, data unmasked");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_cfg_map();
    t_plain();
    t_scrambled();
    t_collision();
    t_reset_clears();
    summary();
  end

endmodule